// File: doc/BRIEF.md
# I/Q Test Signal Generator

This block produces a synthetic complex sample stream for bring-up and self-test of a transceiver signal-processing chain. In tone mode it plays a quadrature sinusoid at one eighth or one quarter of the processing clock. It reads the samples from an eight-point phase table driven by a three-bit phase counter. In constant mode it outputs two held values, one for I and one for Q. Each value is captured from a single shared 16-bit data word when its own load strobe rises.

A shaping stage applies the amplitude choice (full scale, or half amplitude for a 6 dB drop) and an optional I/Q exchange. A final selector then feeds the processing chain with either the normal interface samples or the generator output. The output is combinational from the registered phase and constants, so a control change is visible in the same cycle. A phase or constant update is visible just after the clock edge that makes it.

Top module: `iqtsg_top`

## Requirements
- R1: Synchronous active-high reset clears the phase counter to index 0 and both constant registers to 0. With the generator selected, tone mode, code 01 and half amplitude, the output during reset is I = 16383 and Q = 0.
- R2: With frequency code 01 (clk/8), the phase index advances by one each clock. Q is the table value at the index, and I is the table value at index+2 (mod 8). Table values at index k are 0, D, A, D, 0, -D, -A, -D for k = 0..7, with A = 32767 and D = round(32767·sin 45°) = 23170.
- R3: With frequency code 10 (clk/4), the phase index moves to the next even index each clock. An odd index rounds up. Q therefore cycles 0, +A, 0, -A and I leads Q by one step.
- R4: With frequency codes 00 or 11, the phase index holds and the tone outputs are 0 on both I and Q.
- R5: When the amplitude bit `full_scale` is 0, every generator sample, tone or constant, is the full-scale value arithmetically shifted right by one bit (for example -32768 becomes -16384 and -1 stays -1). When it is 1, the sample is unchanged.
- R6: When `mode_dc` is 1, the generator outputs the constant I register on I and the constant Q register on Q, whatever the frequency code.
- R7: A 0-to-1 transition of `ld_dc_i` (resp. `ld_dc_q`), seen at a clock edge, copies `dc_word` into the constant I (resp. Q) register. While the strobe stays high, later changes of `dc_word` are not captured.
- R8: When `swap_iq` is 1, the generator's I and Q samples are exchanged after amplitude shaping.
- R9: When `sel_gen` is 0, `out_i`/`out_q` equal `in_i`/`in_q` in every generator mode. When it is 1, they carry the generator samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_dc | input | 1 | 0 tone, 1 constant values |
| freq_code | input | 2 | 01 clk/8, 10 clk/4, 00/11 unused |
| full_scale | input | 1 | 1 full scale, 0 half amplitude |
| swap_iq | input | 1 | Exchange generator I and Q |
| sel_gen | input | 1 | 0 interface data, 1 generator |
| dc_word | input | 16 | Shared data word for constant loads |
| ld_dc_i | input | 1 | Rising edge loads constant I |
| ld_dc_q | input | 1 | Rising edge loads constant Q |
| in_i | input | 16 | Normal-path I sample (signed) |
| in_q | input | 16 | Normal-path Q sample (signed) |
| out_i | output | 16 | Selected I sample (signed) |
| out_q | output | 16 | Selected Q sample (signed) |

## Verification
A wrong phase index shows up at once as a table value that does not match the step count since reset or since the last code change. The error stays visible on every later cycle, because the index only ever advances by rule. A missed or repeated constant load shows on the first cycle after the strobe edge, as a held value that differs from the word presented then. Sweeping all codes against amplitude and swap also exposes sign or shift mistakes in the first negative sample, within four cycles.

// File: rtl/iqtsg_pkg.sv
package iqtsg_pkg;

    localparam int SAMP_W  = 16;
    localparam int PHASE_W = 3;
    localparam int LUT_N   = 1 << PHASE_W;
    localparam int QTR     = LUT_N / 4;

    localparam longint AMP_MAX  = (64'sd1 <<< (SAMP_W - 1)) - 1;
    localparam longint AMP_DIAG = (AMP_MAX * 46341 + 32768) >>> 16;
    localparam longint HALF_MAX = AMP_MAX >>> 1;
    localparam longint HALF_MIN = -(64'sd1 <<< (SAMP_W - 2));

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic [PHASE_W-1:0]       phase_t;

    typedef struct packed {
        samp_t i;
        samp_t q;
    } iq_t;

    typedef enum logic [1:0] {
        FR_UNUSED0 = 2'b00,
        FR_DIV8    = 2'b01,
        FR_DIV4    = 2'b10,
        FR_UNUSED3 = 2'b11
    } freq_e;

    function automatic samp_t tone_lut(input phase_t idx);
        samp_t v;
        case (idx)
            3'd1, 3'd3: v = samp_t'(AMP_DIAG);
            3'd2:       v = samp_t'(AMP_MAX);
            3'd5, 3'd7: v = samp_t'(-AMP_DIAG);
            3'd6:       v = samp_t'(-AMP_MAX);
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic samp_t halve(input samp_t x);
        return x >>> 1;
    endfunction

    function automatic logic code_valid(input freq_e c);
        return (c == FR_DIV8) || (c == FR_DIV4);
    endfunction

endpackage

// File: rtl/iqtsg_phase.sv
module iqtsg_phase
    import iqtsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  freq_e freq,
    output iq_t   tone
);

    phase_t phase_q;
    phase_t phase_d;

    always_comb begin
        case (freq)
            FR_DIV8: phase_d = phase_q + phase_t'(1);
            FR_DIV4: phase_d = {phase_q[PHASE_W-1:1], 1'b0} + phase_t'(2);
            default: phase_d = phase_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    always_comb begin
        if (code_valid(freq)) begin
            tone.q = tone_lut(phase_q);
            tone.i = tone_lut(phase_q + phase_t'(QTR));
        end else begin
            tone.q = '0;
            tone.i = '0;
        end
    end

    assert_div8_step_R2: assert property (@(posedge clk) disable iff (rst)
        (freq == FR_DIV8) |=> (phase_q == $past(phase_q) + phase_t'(1)));

    assert_div4_even_R3: assert property (@(posedge clk) disable iff (rst)
        (freq == FR_DIV4) |=> (phase_q[0] == 1'b0));

    assert_unused_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !code_valid(freq) |=> $stable(phase_q));

endmodule

// File: rtl/iqtsg_dcreg.sv
module iqtsg_dcreg
    import iqtsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  samp_t word,
    input  logic  ld_i,
    input  logic  ld_q,
    output iq_t   dc
);

    localparam int NCH = 2;

    logic [NCH-1:0] strobe;
    samp_t          held [NCH];

    assign strobe = {ld_q, ld_i};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic strobe_prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                strobe_prev <= 1'b0;
                held[c]     <= '0;
            end else begin
                strobe_prev <= strobe[c];
                if (strobe[c] && !strobe_prev) held[c] <= word;
            end
        end

        assert_edge_load_R7: assert property (@(posedge clk) disable iff (rst)
            (strobe[c] && !strobe_prev) |=> (held[c] == $past(word)));

        assert_level_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (strobe[c] && strobe_prev) |=> $stable(held[c]));
    end

    assign dc.i = held[0];
    assign dc.q = held[1];

endmodule

// File: rtl/iqtsg_shape.sv
module iqtsg_shape
    import iqtsg_pkg::*;
(
    input  logic mode_dc,
    input  logic full_scale,
    input  logic swap_iq,
    input  iq_t  tone,
    input  iq_t  dc,
    output iq_t  gen
);

    iq_t src;
    iq_t lvl;

    always_comb begin
        src = mode_dc ? dc : tone;
        if (full_scale) begin
            lvl = src;
        end else begin
            lvl.i = halve(src.i);
            lvl.q = halve(src.q);
        end
        if (swap_iq) begin
            gen.i = lvl.q;
            gen.q = lvl.i;
        end else begin
            gen = lvl;
        end
    end

endmodule

// File: rtl/iqtsg_top.sv
module iqtsg_top
    import iqtsg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode_dc,
    input  logic [1:0]               freq_code,
    input  logic                     full_scale,
    input  logic                     swap_iq,
    input  logic                     sel_gen,
    input  logic signed [SAMP_W-1:0] dc_word,
    input  logic                     ld_dc_i,
    input  logic                     ld_dc_q,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q
);

    freq_e freq;
    iq_t   tone;
    iq_t   dc;
    iq_t   gen;

    assign freq = freq_e'(freq_code);

    iqtsg_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .freq (freq),
        .tone (tone)
    );

    iqtsg_dcreg u_dcreg (
        .clk  (clk),
        .rst  (rst),
        .word (dc_word),
        .ld_i (ld_dc_i),
        .ld_q (ld_dc_q),
        .dc   (dc)
    );

    iqtsg_shape u_shape (
        .mode_dc    (mode_dc),
        .full_scale (full_scale),
        .swap_iq    (swap_iq),
        .tone       (tone),
        .dc         (dc),
        .gen        (gen)
    );

    assign out_i = sel_gen ? gen.i : in_i;
    assign out_q = sel_gen ? gen.q : in_q;

    assert_unused_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_gen && !mode_dc && !code_valid(freq)) |-> (out_i == '0 && out_q == '0));

    assert_half_range_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_gen && !full_scale) |->
        (longint'(out_i) <= HALF_MAX && longint'(out_i) >= HALF_MIN &&
         longint'(out_q) <= HALF_MAX && longint'(out_q) >= HALF_MIN));

endmodule

// File: tb/iqtsg_top_tb.sv
module iqtsg_top_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic mode_dc, full_scale, swap_iq, sel_gen, ld_dc_i, ld_dc_q;
    logic [1:0] freq_code;
    logic signed [15:0] dc_word, in_i, in_q, out_i, out_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int mph = 0;
    logic signed [15:0] mdc_i = 0, mdc_q = 0;
    logic mprev_i = 0, mprev_q = 0;
    int diag_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    iqtsg_top u_dut (
        .clk(clk), .rst(rst), .mode_dc(mode_dc), .freq_code(freq_code),
        .full_scale(full_scale), .swap_iq(swap_iq), .sel_gen(sel_gen),
        .dc_word(dc_word), .ld_dc_i(ld_dc_i), .ld_dc_q(ld_dc_q),
        .in_i(in_i), .in_q(in_q), .out_i(out_i), .out_q(out_q)
    );

    function automatic logic signed [15:0] sine_ref(input int k);
        int m;
        int v;
        m = k % 8;
        case (m % 4)
            0: v = 0;
            2: v = 32767;
            default: v = diag_v;
        endcase
        if (m >= 4) v = -v;
        return 16'(v);
    endfunction

    task automatic chk(input string req, input logic signed [15:0] ai, aq, ei, eq);
        n_chk++;
        if (ai !== ei || aq !== eq) begin
            n_fail++;
            $display("FAIL %s: got I=%0d Q=%0d expected I=%0d Q=%0d", req, ai, aq, ei, eq);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            mph = 0; mdc_i = 0; mdc_q = 0; mprev_i = 0; mprev_q = 0;
        end else begin
            if (freq_code == 2'b01)      mph = (mph + 1) % 8;
            else if (freq_code == 2'b10) mph = ((mph / 2) * 2 + 2) % 8;
            if (ld_dc_i && !mprev_i) mdc_i = dc_word;
            if (ld_dc_q && !mprev_q) mdc_q = dc_word;
            mprev_i = ld_dc_i;
            mprev_q = ld_dc_q;
        end
        @(negedge clk);
    endtask

    task automatic gen_expect(output logic signed [15:0] ei, eq);
        logic signed [15:0] ti, tq;
        if (mode_dc) begin
            ti = mdc_i; tq = mdc_q;
        end else if (freq_code == 2'b01 || freq_code == 2'b10) begin
            tq = sine_ref(mph); ti = sine_ref(mph + 2);
        end else begin
            ti = 0; tq = 0;
        end
        if (!full_scale) begin
            ti = ti >>> 1; tq = tq >>> 1;
        end
        if (swap_iq) begin ei = tq; eq = ti; end
        else         begin ei = ti; eq = tq; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic signed [15:0] ei, eq;
        logic [15:0] lfsr;
        logic signed [15:0] vals [6];
        diag_v = $rtoi(32767.0 * 0.7071067811865476 + 0.5);
        vals[0] = -16'sd32768; vals[1] = 16'sd32767; vals[2] = -16'sd1;
        vals[3] = 16'sd1;      vals[4] = 16'sh1234;  vals[5] = -16'sd12345;

        rst = 1; mode_dc = 0; freq_code = 2'b01; full_scale = 0; swap_iq = 0;
        sel_gen = 1; dc_word = 0; ld_dc_i = 0; ld_dc_q = 0; in_i = 0; in_q = 0;
        @(negedge clk);
        step(); step();
        chk("R1 reset tone", out_i, out_q, 16'sd16383, 16'sd0);
        mode_dc = 1; #1;
        chk("R1 reset constants", out_i, out_q, 16'sd0, 16'sd0);
        mode_dc = 0;
        step();
        rst = 0;

        // R2 R3 R4 R5 R8: sweep codes x amplitude x swap
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 4; a++) begin
                freq_code = (c == 0) ? 2'b01 : (c == 1) ? 2'b10 : (c == 2) ? 2'b00 : 2'b11;
                full_scale = a[0];
                swap_iq = a[1];
                for (int s = 0; s < 9; s++) begin
                    step();
                    gen_expect(ei, eq);
                    chk(c == 0 ? "R2 clk/8 tone" : c == 1 ? "R3 clk/4 tone" : "R4 unused code",
                        out_i, out_q, ei, eq);
                end
            end
        end

        // R3 odd phase rounds up
        freq_code = 2'b01; full_scale = 1; swap_iq = 0;
        step();
        freq_code = 2'b10;
        for (int s = 0; s < 4; s++) begin
            step(); gen_expect(ei, eq);
            chk("R3 realign from odd", out_i, out_q, ei, eq);
        end

        // R6 R7 R5 R8 constants
        mode_dc = 1;
        for (int v = 0; v < 6; v++) begin
            dc_word = vals[v]; ld_dc_i = 1;
            step();
            dc_word = vals[(v + 1) % 6];
            step();
            for (int a = 0; a < 4; a++) begin
                full_scale = a[0]; swap_iq = a[1]; #1;
                gen_expect(ei, eq);
                chk("R7 I load, level held", out_i, out_q, ei, eq);
            end
            ld_dc_i = 0; ld_dc_q = 1;
            step();
            dc_word = vals[v];
            step();
            for (int a = 0; a < 4; a++) begin
                full_scale = a[0]; swap_iq = a[1]; #1;
                gen_expect(ei, eq);
                chk("R6 R5 R8 constant out", out_i, out_q, ei, eq);
            end
            ld_dc_q = 0;
            freq_code = 2'(v);
            step();
            gen_expect(ei, eq);
            chk("R6 code ignored", out_i, out_q, ei, eq);
        end

        // R9 passthrough
        sel_gen = 0; lfsr = 16'hACE1;
        for (int s = 0; s < 24; s++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_i = lfsr; in_q = ~lfsr;
            mode_dc = s[0]; freq_code = s[2:1]; full_scale = s[3]; swap_iq = s[4];
            step();
            chk("R9 passthrough", out_i, out_q, in_i, in_q);
        end
        sel_gen = 1; #1;
        gen_expect(ei, eq);
        chk("R9 generator selected", out_i, out_q, ei, eq);

        finish_run();
    end

endmodule